// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Sleep Handling

This block is the digital side of a 10-bit successive-approximation converter. Software reaches it over a small register bus. Through that bus it sets the enable bit, the channel, the reference, the result justification and the conversion clock, and it starts a conversion by setting the GO/DONE bit.

The block drives a trial code to an external DAC and reads back one comparator decision per conversion-clock tick, most significant bit first. When the tenth decision is in, it stores the justified result in two byte registers, clears GO/DONE and raises an interrupt flag. The flag, together with two interrupt enables, produces a wake output.

The block follows the device's sleep request. With the dedicated RC tick selected, the start is held back by one instruction cycle, so the sleep can take hold before the converter starts switching. The conversion then runs to completion while the device is asleep. With any divided system clock selected, sleep kills the conversion in progress. In both cases the analog section is powered down and the enable bit still reads 1.

Top module: `adc_sleep_ctrl`

## Requirements
- R1: Control register (bus address 0): bit 7 = format (1 right-justified, 0 left-justified), bit 6 = reference select, bit 5 always reads 0, bits 4:2 = channel, bit 1 = GO/DONE, bit 0 = enable. After reset it reads 0x00. The channel and reference bits appear on `chanSel` and `refSel`.
- R2: Clock register (address 1): only bits 6:4 are stored and all other bits read 0. After reset it reads 0x00.
- R3: A conversion makes 10 comparator decisions, MSB first, one per conversion-clock tick, and the stored result equals the code at which the comparator switches. Clock select codes with low bits 11 use the `rcTick` input. Any other code s divides the system clock by 2^(2*s[1:0]+1+s[2]), so code 000 gives a GO/DONE period of exactly 20 cycles.
- R4: On completion, GO/DONE reads 0, the result registers are loaded and the flag (address 4, bit 0) becomes 1.
- R5: Result registers are address 2 (high) and address 3 (low). With left justification, high holds result[9:2] and low holds result[1:0] in bits 7:6. With right justification, high holds result[9:8] in bits 1:0 and low holds result[7:0].
- R6: A write with GO=1 starts a conversion only when the enable bit was already 1 and the same write keeps it 1. Otherwise GO reads 0 and nothing runs.
- R7: With the RC tick selected, the first trial code (0x200) appears on `dacCode` on the fourth clock edge after the GO write (an instruction cycle of 4 clocks). Until then `dacCode` is unchanged.
- R8: With the RC tick selected, a conversion runs to completion while `sleepReq` is high and keeps `anaPowerEn` at 1 until it completes. Afterwards `anaPowerEn` is 0 while asleep and the enable bit still reads 1.
- R9: With a divided clock selected, `sleepReq` during a conversion aborts it. GO/DONE reads 0, the flag stays 0, the results are unchanged, `anaPowerEn` is 0 and the enable bit reads 1.
- R10: Reset clears the control, clock and flag registers and aborts any conversion. The result registers keep their contents.
- R11: The flag stays set until software writes 0 to address 4 bit 0. `wakeOut` is 1 exactly when the flag, `adcIntEn` and `periphIntEn` are all 1.
- R12: A write to the control register during a conversion with GO=0 or enable=0 aborts it without setting the flag or changing the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| sleepReq | input | 1 | Device is asleep |
| adcIntEn | input | 1 | ADC interrupt enable |
| periphIntEn | input | 1 | Peripheral interrupt enable |
| rcTick | input | 1 | One-cycle pulse from the dedicated RC conversion clock |
| cmpIn | input | 1 | Comparator: 1 when the input is at or above dacCode |
| dacCode | output | 10 | Trial code for the DAC |
| chanSel | output | 3 | Analog channel select |
| refSel | output | 1 | Reference select |
| anaPowerEn | output | 1 | Power enable for the analog section |
| wakeOut | output | 1 | Wake/interrupt request |

## Verification
The hardest state to reach from the ports is a conversion that is still running while the device sleeps, together with the moment the delayed RC start takes effect.

The bench reaches the first by selecting the RC tick, writing GO, raising `sleepReq` on the next cycle, and only then feeding `rcTick` pulses one at a time.

It reaches the second by first leaving a known partial code on `dacCode`: an earlier conversion on the slowest divider is aborted after exactly one decision. The bench can then tell the edge on which 0x200 appears. The comparator is modelled as a plain compare between a chosen input level and `dacCode`, so every result is predictable.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESLO = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_CONV  = 2'd2
  } convState_t;

  typedef struct packed {
    logic start;
    logic step;
    logic fmtRight;
  } dpCmd_t;
endpackage

// File: rtl/adc_sar_dp.sv
module adc_sar_dp
  import adc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpIn,
  input  dpCmd_t            dpCmd,
  output logic              lastStep,
  output logic [RES_W-1:0]  dacCode,
  output logic [BYTE_W-1:0] resHi,
  output logic [BYTE_W-1:0] resLo
);
  localparam int IDX_W    = $clog2(RES_W);
  localparam int LOW_BITS = RES_W - BYTE_W;
  localparam int PAD_W    = BYTE_W - LOW_BITS;

  logic [RES_W-1:0] sarQ, sarNext;
  logic [IDX_W-1:0] idxQ;

  assign lastStep = (idxQ == '0);
  assign dacCode  = sarQ;

  // Resolve the current bit and place the next trial bit below it.
  always_comb begin
    sarNext = sarQ;
    for (int i = 0; i < RES_W; i++) begin
      if (IDX_W'(i) == idxQ) sarNext[i] = cmpIn;
      if ((i + 1 < RES_W) && (IDX_W'(i + 1) == idxQ)) sarNext[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ <= '0;
      idxQ <= '0;
    end else if (dpCmd.start) begin
      sarQ <= {1'b1, {(RES_W-1){1'b0}}};
      idxQ <= IDX_W'(RES_W - 1);
    end else if (dpCmd.step) begin
      sarQ <= sarNext;
      if (!lastStep) idxQ <= idxQ - 1'b1;
    end
  end

  // Result bytes survive reset on purpose: no reset branch.
  always_ff @(posedge clk) begin
    if (dpCmd.step && lastStep) begin
      if (dpCmd.fmtRight) begin
        resHi <= {{PAD_W{1'b0}}, sarNext[RES_W-1:BYTE_W]};
        resLo <= sarNext[BYTE_W-1:0];
      end else begin
        resHi <= sarNext[RES_W-1:LOW_BITS];
        resLo <= {sarNext[LOW_BITS-1:0], {PAD_W{1'b0}}};
      end
    end
  end

  // R3: each conversion opens with only the MSB trial bit set
  p_start_msb_r3: assert property (@(posedge clk) disable iff (!rstN)
    dpCmd.start |=> (dacCode == {1'b1, {(RES_W-1){1'b0}}}));
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_pkg::*;
#(
  parameter int INSTR_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [BYTE_W-1:0] resHi,
  input  logic [BYTE_W-1:0] resLo,
  input  logic              sleepReq,
  input  logic              adcIntEn,
  input  logic              periphIntEn,
  input  logic              rcTick,
  input  logic              lastStep,
  output dpCmd_t            dpCmd,
  output logic [2:0]        chanSel,
  output logic              refSel,
  output logic              anaPowerEn,
  output logic              wakeOut
);
  localparam int DLY_W = (INSTR_CLKS > 1) ? $clog2(INSTR_CLKS) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(INSTR_CLKS - 1);

  convState_t        state;
  logic              fmtQ, refQ, adonQ, flagQ;
  logic [2:0]        chsQ, clkSelQ;
  logic [DLY_W-1:0]  delayCnt;
  logic [DIV_W-1:0]  divCnt, divLast;
  logic [2:0]        divExp;
  logic              rcSel, busy, divTick, stepTick;
  logic              wrCtrl, wrClk, wrFlag;
  logic              swAbort, slAbort, abort, startReq, convDone;
  logic              unusedBits;

  assign rcSel   = (clkSelQ[1:0] == 2'b11);
  assign busy    = (state != ST_IDLE);
  assign divExp  = {clkSelQ[1:0], 1'b0} + 3'd1 + {2'b00, clkSelQ[2]};
  assign divLast = (DIV_W'(1) << divExp) - DIV_W'(1);
  assign divTick = (divCnt == divLast);
  assign stepTick = rcSel ? rcTick : divTick;

  assign wrCtrl = busWe && (busAddr == A_CTRL);
  assign wrClk  = busWe && (busAddr == A_CLK);
  assign wrFlag = busWe && (busAddr == A_FLAG);

  assign swAbort  = busy && wrCtrl && (!busWdata[0] || !busWdata[1]);
  assign slAbort  = busy && sleepReq && !rcSel;
  assign abort    = swAbort || slAbort;
  assign startReq = !busy && wrCtrl && busWdata[1] && busWdata[0] && adonQ;

  always_comb begin
    dpCmd.fmtRight = fmtQ;
    dpCmd.start = (!busy && startReq && !rcSel) ||
                  ((state == ST_DELAY) && (delayCnt == DLY_LAST) && !abort);
    dpCmd.step  = (state == ST_CONV) && stepTick && !abort;
  end
  assign convDone = dpCmd.step && lastStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtQ     <= 1'b0;
      refQ     <= 1'b0;
      chsQ     <= '0;
      adonQ    <= 1'b0;
      clkSelQ  <= '0;
      flagQ    <= 1'b0;
      state    <= ST_IDLE;
      delayCnt <= '0;
      divCnt   <= '0;
    end else begin
      if (wrCtrl) begin
        fmtQ  <= busWdata[7];
        refQ  <= busWdata[6];
        chsQ  <= busWdata[4:2];
        adonQ <= busWdata[0];
      end
      if (wrClk) clkSelQ <= busWdata[6:4];
      if (convDone)    flagQ <= 1'b1;
      else if (wrFlag) flagQ <= busWdata[0];

      if (abort) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (startReq) begin
            state    <= rcSel ? ST_DELAY : ST_CONV;
            delayCnt <= '0;
            divCnt   <= '0;
          end
          ST_DELAY: begin
            if (delayCnt == DLY_LAST) begin
              state  <= ST_CONV;
              divCnt <= '0;
            end else begin
              delayCnt <= delayCnt + 1'b1;
            end
          end
          ST_CONV: begin
            divCnt <= divTick ? '0 : divCnt + 1'b1;
            if (convDone) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      A_CTRL:  busRdata = {fmtQ, refQ, 1'b0, chsQ, busy, adonQ};
      A_CLK:   busRdata = {1'b0, clkSelQ, 4'b0000};
      A_RESHI: busRdata = resHi;
      A_RESLO: busRdata = resLo;
      A_FLAG:  busRdata = {7'b0, flagQ};
      default: busRdata = '0;
    endcase
  end

  assign chanSel    = chsQ;
  assign refSel     = refQ;
  assign anaPowerEn = adonQ && (!sleepReq || (rcSel && busy));
  assign wakeOut    = flagQ && adcIntEn && periphIntEn;
  assign unusedBits = ^{busWdata[5], busWdata[3:1], busWdata[7]};

  // R6: a running conversion implies the enable bit is set
  p_busy_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> adonQ);

  // R6: with enable clear, an idle converter stays idle
  p_go_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !adonQ) |=> !busy);

  // R7: no decision is taken while the RC start is held back
  p_delay_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DELAY) |-> !dpCmd.step);

  // R9: sleep on a divided clock returns to idle without raising the flag
  p_sleep_abort_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sleepReq && !rcSel && !wrFlag) |=> (!busy && !$rose(flagQ)));

  // R4: the flag only rises from a finished conversion or a software write
  p_flag_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> ($past(state) == ST_CONV || $past(wrFlag)));
endmodule

// File: rtl/adc_sleep_ctrl.sv
module adc_sleep_ctrl
  import adc_pkg::*;
#(
  parameter int INSTR_CLKS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWe,
  input  logic [2:0]   busAddr,
  input  logic [7:0]   busWdata,
  output logic [7:0]   busRdata,
  input  logic         sleepReq,
  input  logic         adcIntEn,
  input  logic         periphIntEn,
  input  logic         rcTick,
  input  logic         cmpIn,
  output logic [9:0]   dacCode,
  output logic [2:0]   chanSel,
  output logic         refSel,
  output logic         anaPowerEn,
  output logic         wakeOut
);
  dpCmd_t            dpCmd;
  logic              lastStep;
  logic [BYTE_W-1:0] resHi, resLo;

  adc_ctrl #(.INSTR_CLKS(INSTR_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .resHi(resHi), .resLo(resLo),
    .sleepReq(sleepReq), .adcIntEn(adcIntEn), .periphIntEn(periphIntEn),
    .rcTick(rcTick), .lastStep(lastStep), .dpCmd(dpCmd), .chanSel(chanSel),
    .refSel(refSel), .anaPowerEn(anaPowerEn), .wakeOut(wakeOut)
  );

  adc_sar_dp u_dp (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn), .dpCmd(dpCmd),
    .lastStep(lastStep), .dacCode(dacCode), .resHi(resHi), .resLo(resLo)
  );
endmodule

// File: tb/adc_sleep_ctrl_tb.sv
module adc_sleep_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sleepReq = 1'b0, adcIntEn = 1'b0, periphIntEn = 1'b0, rcTick = 1'b0;
  logic       cmpIn;
  logic [9:0] dacCode, vin = '0;
  logic [2:0] chanSel;
  logic       refSel, anaPowerEn, wakeOut;
  int         tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmpIn = (vin >= dacCode);

  adc_sleep_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sleepReq(sleepReq),
    .adcIntEn(adcIntEn), .periphIntEn(periphIntEn), .rcTick(rcTick),
    .cmpIn(cmpIn), .dacCode(dacCode), .chanSel(chanSel), .refSel(refSel),
    .anaPowerEn(anaPowerEn), .wakeOut(wakeOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitDone();
    logic [7:0] c;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd0, c);
      if (!c[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic rcPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rcTick = 1'b1;
      @(negedge clk); rcTick = 1'b0;
    end
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(3'd0, d); check("R1 ctrl reset", d, 8'h00);
    rd(3'd1, d); check("R2 clk reset", d, 8'h00);
    rd(3'd4, d); check("R11 flag reset", d, 8'h00);
    check("R11 wake reset", wakeOut, 1'b0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(3'd0, 8'hFF);
    rd(3'd0, d); check("R1 ctrl bits, R6 go ignored", d, 8'hDD);
    check("R1 chanSel", chanSel, 3'd7);
    check("R1 refSel", refSel, 1'b1);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); check("R2 clk bits", d, 8'h70);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_go_ignored();
    logic [7:0] d;
    wr(3'd0, 8'h03);
    rd(3'd0, d); check("R6 go with enable off", d, 8'h01);
    repeat (5) @(negedge clk);
    rd(3'd0, d); check("R6 still idle", d, 8'h01);
    rd(3'd4, d); check("R6 no flag", d, 8'h00);
  endtask

  task automatic t_right_div2();
    logic [7:0] d;
    vin = 10'h2B7;
    wr(3'd0, 8'h83);
    repeat (19) @(negedge clk);
    rd(3'd0, d); check("R3 busy at 19", d[1], 1'b1);
    @(negedge clk);
    rd(3'd0, d); check("R3 R4 done at 20", d, 8'h81);
    rd(3'd4, d); check("R4 flag", d, 8'h01);
    rd(3'd2, d); check("R5 right hi", d, 8'h02);
    rd(3'd3, d); check("R5 right lo", d, 8'hB7);
  endtask

  task automatic t_left_wake();
    logic [7:0] d;
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R11 flag cleared", d, 8'h00);
    vin = 10'h155;
    adcIntEn = 1'b1; periphIntEn = 1'b0;
    wr(3'd0, 8'h03);
    waitDone();
    rd(3'd2, d); check("R5 left hi", d, 8'h55);
    rd(3'd3, d); check("R5 left lo", d, 8'h40);
    check("R11 wake needs periph", wakeOut, 1'b0);
    periphIntEn = 1'b1;
    #1 check("R11 wake", wakeOut, 1'b1);
    repeat (10) @(negedge clk);
    rd(3'd4, d); check("R11 flag held", d, 8'h01);
    adcIntEn = 1'b0;
    #1 check("R11 wake needs adc en", wakeOut, 1'b0);
  endtask

  task automatic t_sw_abort();
    logic [7:0] d;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h60);
    vin = 10'h3FF;
    wr(3'd0, 8'h03);
    repeat (100) @(negedge clk);
    wr(3'd0, 8'h01);
    rd(3'd0, d); check("R12 go cleared", d, 8'h01);
    rd(3'd4, d); check("R12 no flag", d, 8'h00);
    rd(3'd2, d); check("R12 hi kept", d, 8'h55);
    rd(3'd3, d); check("R12 lo kept", d, 8'h40);
    check("R3 one decision at div64", dacCode, 10'h300);
  endtask

  task automatic t_rc_sleep_wake();
    logic [7:0] d;
    wr(3'd1, 8'h30);
    vin = 10'h0F0;
    adcIntEn = 1'b1; periphIntEn = 1'b1;
    wr(3'd0, 8'h03);
    sleepReq = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 code held during delay", dacCode, 10'h300);
    rd(3'd0, d); check("R7 go set during delay", d[1], 1'b1);
    @(negedge clk);
    check("R7 first trial after delay", dacCode, 10'h200);
    check("R8 powered while converting asleep", anaPowerEn, 1'b1);
    rcPulses(10);
    rd(3'd0, d); check("R8 done asleep", d, 8'h01);
    rd(3'd4, d); check("R8 flag", d, 8'h01);
    check("R8 wake", wakeOut, 1'b1);
    rd(3'd2, d); check("R8 hi", d, 8'h3C);
    rd(3'd3, d); check("R8 lo", d, 8'h00);
    check("R8 power off after", anaPowerEn, 1'b0);
  endtask

  task automatic t_rc_sleep_noint();
    logic [7:0] d;
    sleepReq = 1'b0;
    adcIntEn = 1'b0;
    wr(3'd4, 8'h00);
    vin = 10'h001;
    wr(3'd0, 8'h03);
    sleepReq = 1'b1;
    repeat (4) @(negedge clk);
    rcPulses(10);
    rd(3'd4, d); check("R8 flag no int", d, 8'h01);
    check("R8 no wake", wakeOut, 1'b0);
    check("R8 powered down", anaPowerEn, 1'b0);
    rd(3'd0, d); check("R8 enable stays", d, 8'h01);
    rd(3'd3, d); check("R8 lo result", d, 8'h40);
  endtask

  task automatic t_div_sleep_abort();
    logic [7:0] d;
    sleepReq = 1'b0;
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);
    vin = 10'h3AA;
    wr(3'd0, 8'h03);
    repeat (5) @(negedge clk);
    sleepReq = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd0, d); check("R9 aborted, enable stays", d, 8'h01);
    rd(3'd4, d); check("R9 no flag", d, 8'h00);
    rd(3'd2, d); check("R9 hi kept", d, 8'h00);
    rd(3'd3, d); check("R9 lo kept", d, 8'h40);
    check("R9 power off", anaPowerEn, 1'b0);
    repeat (30) @(negedge clk);
    rd(3'd4, d); check("R9 still no flag", d, 8'h00);
    sleepReq = 1'b0;
    #1 check("R9 power back on wake", anaPowerEn, 1'b1);
  endtask

  task automatic t_reset_mid();
    logic [7:0] d;
    vin = 10'h123;
    wr(3'd0, 8'h83);
    waitDone();
    rd(3'd4, d); check("R10 flag before reset", d, 8'h01);
    wr(3'd1, 8'h40);
    vin = 10'h3FF;
    wr(3'd0, 8'h83);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(3'd0, d); check("R10 ctrl cleared", d, 8'h00);
    rd(3'd1, d); check("R10 clk cleared", d, 8'h00);
    rd(3'd4, d); check("R10 flag cleared", d, 8'h00);
    rd(3'd2, d); check("R10 hi kept", d, 8'h01);
    rd(3'd3, d); check("R10 lo kept", d, 8'h23);
    check("R10 power off", anaPowerEn, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_layout();
    t_go_ignored();
    t_right_div2();
    t_left_wake();
    t_sw_abort();
    t_rc_sleep_wake();
    t_rc_sleep_noint();
    t_div_sleep_abort();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule